// File: doc/BRIEF.md
# Dual-Output Maskable Interrupt Controller

This block gathers a wide set of interrupt request lines and folds them onto two interrupt outputs. Every source carries four configuration bits of its own: whether it is edge or level triggered, which polarity counts as active, which of the two outputs it feeds, and whether it is enabled at all. Edge-triggered sources latch a pending bit on their active transition, which software removes by writing a one to the matching bit of a clear array. Level-triggered sources present their polarity-corrected input level directly.

Software uses a small synchronous register port with two regions selected by a region bit. It is a word address, a write strobe, write data and registered read data. Region 0 holds the configuration arrays. Region 1 holds the clear array, the masked-pending arrays for each output and a summary word. The summary word tells a handler which 32-source groups hold pending work for each output, so it can reach the right pending word with one more read. Request inputs are resynchronised through two flops before any use.

Top module: `intc_dual_top`

## Requirements
- R1: After a synchronous reset every source is level triggered, active high, routed to output 1 and disabled. No pending state remains, both outputs are low and every register reads zero.
- R2: In region 0 the word address selects a configuration word as array*7+group. Array 0 is trigger type (1 = edge), array 1 is polarity (1 = active low / falling), array 2 is output select (1 = output 0) and array 3 is enable (1 = enabled). A written word reads back unchanged one cycle after its address is presented.
- R3: A level source reports its synchronised input XOR its polarity bit as pending. It holds no latched state.
- R4: An edge source latches pending on a rising input when polarity is 0 and on a falling input when polarity is 1. The pending bit stays set after the input returns.
- R5: Writing region 1 words 0..6 clears the pending bits of that group whose write-data bits are 1 and leaves the others alone. Those words read as zero.
- R6: When a new qualified edge and a clear of the same source fall in the same cycle, the pending bit ends up set.
- R7: A disabled source is absent from the masked-pending words, the summary and the outputs. Its latched edge pending is kept and appears again once it is re-enabled.
- R8: Region 1 words 7+group report masked pending for sources routed to output 1, and words 14+group report it for sources routed to output 0. A source appears in exactly one of them.
- R9: Region 1 word 31 is the summary. Bit g (g = 0..6) is set when group g has masked pending for output 1, and bit 8+g is set when it has masked pending for output 0. All other bits read zero.
- R10: Each output is a registered level that is high while any of its masked-pending words is nonzero.
- R11: Unused addresses read zero. Writes to region 1 outside the clear array, and writes to unused region 0 addresses, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_SRC (224) | Asynchronous interrupt request lines |
| reg_region | input | 1 | Register region select (0 = configuration, 1 = status/clear) |
| reg_addr | input | ADDR_W (5) | Word address within the region |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered from the address of the previous cycle |
| irq_out0 | output | 1 | Interrupt output 0 |
| irq_out1 | output | 1 | Interrupt output 1 |

## Verification
On every cycle the assertions check several properties. A latched edge pending bit survives unless it is cleared. A coincident edge and clear leaves it set. A level source never holds latched state. No source shows up on both outputs. Each output follows its group flags one cycle later, and the reserved summary bits stay zero. The scenarios show the rest: configuration readback at the array boundaries, the polarity of level and edge qualification, the masking and re-enabling of retained pending state, the routing to each output and its summary bit, and the cycle-exact race between edge and clear. They also show that stray writes have no effect, which the bench checks through later reads.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int unsigned WORD_W      = 32;
  localparam int unsigned NUM_ARRAYS  = 4;
  localparam int unsigned SUM_O0_BASE = 8;

  typedef enum logic [1:0] {
    ARR_TYPE  = 2'd0,
    ARR_POL   = 2'd1,
    ARR_ROUTE = 2'd2,
    ARR_EN    = 2'd3
  } cfg_arr_e;

  function automatic logic [WORD_W-1:0] impl_mask(input int unsigned nsrc, input int unsigned grp);
    int unsigned nb;
    logic [WORD_W-1:0] m;
    nb = (nsrc > grp * WORD_W) ? nsrc - grp * WORD_W : 0;
    if (nb >= WORD_W) nb = WORD_W;
    m = '0;
    for (int unsigned i = 0; i < WORD_W; i++) m[i] = (i < nb);
    return m;
  endfunction
endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      q_o    <= '0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/intc_group.sv
module intc_group
  import intc_pkg::*;
#(
  parameter logic [WORD_W-1:0] IMPL = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] lvl_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              we_type_i,
  input  logic              we_pol_i,
  input  logic              we_route_i,
  input  logic              we_en_i,
  input  logic              we_clr_i,
  output logic [WORD_W-1:0] type_o,
  output logic [WORD_W-1:0] pol_o,
  output logic [WORD_W-1:0] route_o,
  output logic [WORD_W-1:0] en_o,
  output logic [WORD_W-1:0] masked0_o,
  output logic [WORD_W-1:0] masked1_o
);
  logic [WORD_W-1:0] type_q, pol_q, route_q, en_q, pend_q, prev_q;
  logic [WORD_W-1:0] qual_w, edge_w, clr_w, status_w, masked_w;

  assign qual_w   = (lvl_i ^ pol_q) & IMPL;
  assign edge_w   = qual_w & ~prev_q;
  assign clr_w    = we_clr_i ? wdata_i : '0;
  assign status_w = (type_q & pend_q) | (~type_q & qual_w);
  assign masked_w = status_w & en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      type_q  <= '0;
      pol_q   <= '0;
      route_q <= '0;
      en_q    <= '0;
      pend_q  <= '0;
      prev_q  <= '0;
    end else begin
      if (we_type_i)  type_q  <= wdata_i & IMPL;
      if (we_pol_i)   pol_q   <= wdata_i & IMPL;
      if (we_route_i) route_q <= wdata_i & IMPL;
      if (we_en_i)    en_q    <= wdata_i & IMPL;
      prev_q <= qual_w;
      pend_q <= type_q & (edge_w | (pend_q & ~clr_w)) & IMPL;
    end
  end

  assign type_o    = type_q;
  assign pol_o     = pol_q;
  assign route_o   = route_q;
  assign en_o      = en_q;
  assign masked0_o = masked_w & route_q;
  assign masked1_o = masked_w & ~route_q;

  AST_PEND_HELD: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend_q & $past(pend_q & type_q & ~clr_w)) == $past(pend_q & type_q & ~clr_w))); // R4
  AST_EDGE_BEATS_CLR: assert property (@(posedge clk) disable iff (rst)
    (|(edge_w & type_q & clr_w)) |=> ((pend_q & $past(edge_w & type_q)) == $past(edge_w & type_q))); // R6
  AST_LEVEL_NO_LATCH: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend_q & ~$past(type_q)) == '0)); // R3
  AST_SINGLE_OUTPUT: assert property (@(posedge clk) disable iff (rst)
    (masked0_o & masked1_o) == '0); // R8
endmodule

// File: rtl/intc_dual_top.sv
module intc_dual_top
  import intc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 224,
  parameter int unsigned ADDR_W  = $clog2(NUM_ARRAYS * ((NUM_SRC + WORD_W - 1) / WORD_W) + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] irq_in,
  input  logic               reg_region,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               reg_we,
  input  logic [WORD_W-1:0]  reg_wdata,
  output logic [WORD_W-1:0]  reg_rdata,
  output logic               irq_out0,
  output logic               irq_out1
);
  localparam int unsigned NGRP     = (NUM_SRC + WORD_W - 1) / WORD_W;
  localparam int unsigned PAD_W    = NGRP * WORD_W;
  localparam logic [ADDR_W-1:0] SUM_ADDR = '1;

  logic [NUM_SRC-1:0] sync_w;
  logic [PAD_W-1:0]   lvl_pad;
  logic [WORD_W-1:0]  type_w [NGRP];
  logic [WORD_W-1:0]  pol_w  [NGRP];
  logic [WORD_W-1:0]  route_w[NGRP];
  logic [WORD_W-1:0]  en_w   [NGRP];
  logic [WORD_W-1:0]  m0_w   [NGRP];
  logic [WORD_W-1:0]  m1_w   [NGRP];
  logic [NGRP-1:0]    grp0_w, grp1_w;
  logic [WORD_W-1:0]  summary_w, rd_nxt;
  int unsigned        addr_i;

  intc_sync #(.WIDTH(NUM_SRC)) u_sync (
    .clk(clk), .rst(rst), .d_i(irq_in), .q_o(sync_w)
  );

  always_comb begin
    lvl_pad = '0;
    lvl_pad[NUM_SRC-1:0] = sync_w;
  end

  assign addr_i = int'(reg_addr);

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam logic [WORD_W-1:0] GMASK = impl_mask(NUM_SRC, g);
    logic wt, wp, wr, wen, wc;
    assign wt  = reg_we && !reg_region && (addr_i == int'(ARR_TYPE)  * NGRP + g);
    assign wp  = reg_we && !reg_region && (addr_i == int'(ARR_POL)   * NGRP + g);
    assign wr  = reg_we && !reg_region && (addr_i == int'(ARR_ROUTE) * NGRP + g);
    assign wen = reg_we && !reg_region && (addr_i == int'(ARR_EN)    * NGRP + g);
    assign wc  = reg_we &&  reg_region && (addr_i == g);

    intc_group #(.IMPL(GMASK)) u_grp (
      .clk(clk), .rst(rst),
      .lvl_i(lvl_pad[g*WORD_W +: WORD_W]),
      .wdata_i(reg_wdata),
      .we_type_i(wt), .we_pol_i(wp), .we_route_i(wr), .we_en_i(wen), .we_clr_i(wc),
      .type_o(type_w[g]), .pol_o(pol_w[g]), .route_o(route_w[g]), .en_o(en_w[g]),
      .masked0_o(m0_w[g]), .masked1_o(m1_w[g])
    );
    assign grp0_w[g] = |m0_w[g];
    assign grp1_w[g] = |m1_w[g];
  end

  always_comb begin
    summary_w = '0;
    summary_w[NGRP-1:0] = grp1_w;
    summary_w[SUM_O0_BASE +: NGRP] = grp0_w;
  end

  always_comb begin
    rd_nxt = '0;
    for (int g = 0; g < NGRP; g++) begin
      if (!reg_region) begin
        if (addr_i == int'(ARR_TYPE)  * NGRP + g) rd_nxt = type_w[g];
        if (addr_i == int'(ARR_POL)   * NGRP + g) rd_nxt = pol_w[g];
        if (addr_i == int'(ARR_ROUTE) * NGRP + g) rd_nxt = route_w[g];
        if (addr_i == int'(ARR_EN)    * NGRP + g) rd_nxt = en_w[g];
      end else begin
        if (addr_i == NGRP + g)     rd_nxt = m1_w[g];
        if (addr_i == 2 * NGRP + g) rd_nxt = m0_w[g];
      end
    end
    if (reg_region && reg_addr == SUM_ADDR) rd_nxt = summary_w;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      irq_out0  <= 1'b0;
      irq_out1  <= 1'b0;
    end else begin
      reg_rdata <= rd_nxt;
      irq_out0  <= |grp0_w;
      irq_out1  <= |grp1_w;
    end
  end

  AST_OUT0_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_out0 == $past(|grp0_w))); // R10
  AST_OUT1_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_out1 == $past(|grp1_w))); // R10
  AST_SUMMARY_RSVD: assert property (@(posedge clk) disable iff (rst)
    (reg_region && reg_addr == SUM_ADDR) |=>
      (reg_rdata[WORD_W-1:SUM_O0_BASE+NGRP] == '0 && reg_rdata[SUM_O0_BASE-1:NGRP] == '0)); // R9
endmodule

// File: tb/intc_dual_top_tb.sv
module intc_dual_top_tb;
  localparam int NS = 224;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NS-1:0] irq_in = '0;
  logic          reg_region = 1'b0;
  logic [4:0]    reg_addr = '0;
  logic          reg_we = 1'b0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          irq_out0, irq_out1;

  int n_chk = 0;
  int n_bad = 0;

  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t sb_q[$];
  logic  issue = 1'b0;
  logic  issue_d = 1'b0;

  always #2 clk = ~clk;

  intc_dual_top u_dut (
    .clk(clk), .rst(rst), .irq_in(irq_in), .reg_region(reg_region), .reg_addr(reg_addr),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_out0(irq_out0), .irq_out1(irq_out1)
  );

  always @(posedge clk) issue_d <= issue;

  always @(negedge clk) begin
    if (issue_d) begin
      item_t it;
      it = sb_q.pop_front();
      n_chk++;
      if (reg_rdata !== it.exp) begin
        n_bad++;
        $display("FAIL %s: read got %h expected %h", it.tag, reg_rdata, it.exp);
      end
    end
  end

  task automatic wr(input logic rg, input int a, input logic [31:0] d);
    @(negedge clk);
    reg_region = rg; reg_addr = 5'(a); reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic rg, input int a, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk);
    reg_region = rg; reg_addr = 5'(a);
    it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    issue = 1'b1;
    @(negedge clk);
    issue = 1'b0;
    @(negedge clk);
  endtask

  task automatic chk_out(input logic e0, input logic e1, input string tag);
    n_chk++;
    if (irq_out0 !== e0 || irq_out1 !== e1) begin
      n_bad++;
      $display("FAIL %s: outputs got %b%b expected %b%b", tag, irq_out0, irq_out1, e0, e1);
    end
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    settle();
    // R1 reset state
    chk_out(1'b0, 1'b0, "R1");
    rd(0, 0, 32'h0, "R1"); rd(0, 27, 32'h0, "R1"); rd(1, 31, 32'h0, "R1");
    // R2 readback at array boundaries
    wr(0, 0, 32'hA5A5_0001); wr(0, 13, 32'h8000_0003); wr(0, 14, 32'h1234_5678); wr(0, 27, 32'hFFFF_FFFF);
    rd(0, 0, 32'hA5A5_0001, "R2"); rd(0, 13, 32'h8000_0003, "R2");
    rd(0, 14, 32'h1234_5678, "R2"); rd(0, 27, 32'hFFFF_FFFF, "R2");
    wr(0, 0, 0); wr(0, 13, 0); wr(0, 14, 0); wr(0, 27, 0);
    // R11 unused addresses and stray writes
    wr(0, 28, 32'hFFFF_FFFF); wr(1, 7, 32'hFFFF_FFFF); wr(1, 20, 32'hFFFF_FFFF);
    rd(0, 28, 32'h0, "R11"); rd(1, 7, 32'h0, "R11"); rd(1, 25, 32'h0, "R11");
    settle();
    chk_out(1'b0, 1'b0, "R11");
    // R3 level source 5 routed to output 0
    wr(0, 21, 32'h20); wr(0, 14, 32'h20);
    irq_in[5] = 1'b1; settle();
    rd(1, 14, 32'h20, "R3"); chk_out(1'b1, 1'b0, "R3");
    rd(1, 7, 32'h0, "R8");
    irq_in[5] = 1'b0; settle();
    rd(1, 14, 32'h0, "R3"); chk_out(1'b0, 1'b0, "R3");
    wr(0, 7, 32'h20); settle();
    rd(1, 14, 32'h20, "R3"); chk_out(1'b1, 1'b0, "R3");
    wr(0, 7, 0); wr(0, 21, 0); wr(0, 14, 0); settle();
    // R8 R9 source 40 (group 1 bit 8) to output 1, source 223 (group 6 bit 31) to output 0
    wr(0, 22, 32'h100); wr(0, 27, 32'h8000_0000); wr(0, 20, 32'h8000_0000);
    irq_in[40] = 1'b1; irq_in[223] = 1'b1; settle();
    rd(1, 8, 32'h100, "R8"); rd(1, 15, 32'h0, "R8"); rd(1, 20, 32'h8000_0000, "R8");
    rd(1, 31, 32'h0000_4002, "R9"); chk_out(1'b1, 1'b1, "R10");
    irq_in[223] = 1'b0; settle();
    rd(1, 31, 32'h0000_0002, "R9"); chk_out(1'b0, 1'b1, "R10");
    irq_in[40] = 1'b0; wr(0, 22, 0); wr(0, 27, 0); wr(0, 20, 0); settle();
    // R4 rising edge on source 100 (group 3 bit 4) to output 0
    wr(0, 3, 32'h10); wr(0, 24, 32'h10); wr(0, 17, 32'h10); settle();
    rd(1, 17, 32'h0, "R4");
    irq_in[100] = 1'b1; repeat (2) @(negedge clk); irq_in[100] = 1'b0; settle();
    rd(1, 17, 32'h10, "R4"); chk_out(1'b1, 1'b0, "R4");
    // R7 mask keeps pending
    wr(0, 24, 0); settle();
    rd(1, 17, 32'h0, "R7"); rd(1, 31, 32'h0, "R7"); chk_out(1'b0, 1'b0, "R7");
    wr(0, 24, 32'h10); settle();
    rd(1, 17, 32'h10, "R7"); chk_out(1'b1, 1'b0, "R7");
    // R5 clear
    wr(1, 3, 32'hFFFF_FFEF); settle();
    rd(1, 17, 32'h10, "R5");
    wr(1, 3, 32'h10); settle();
    rd(1, 17, 32'h0, "R5"); rd(1, 3, 32'h0, "R5"); chk_out(1'b0, 1'b0, "R5");
    // R6 edge coincident with clear
    @(negedge clk); irq_in[100] = 1'b1;
    @(negedge clk);
    @(negedge clk); reg_region = 1'b1; reg_addr = 5'd3; reg_wdata = 32'h10; reg_we = 1'b1;
    @(negedge clk); reg_we = 1'b0;
    settle();
    rd(1, 17, 32'h10, "R6");
    irq_in[100] = 1'b0; wr(1, 3, 32'h10); settle();
    // R4 falling edge on source 101 (group 3 bit 5), polarity set first
    wr(0, 10, 32'h20); wr(0, 24, 32'h20); wr(0, 17, 32'h20); settle();
    wr(0, 3, 32'h20); wr(1, 3, 32'h20); settle();
    rd(1, 17, 32'h0, "R4");
    irq_in[101] = 1'b1; settle();
    rd(1, 17, 32'h0, "R4");
    irq_in[101] = 1'b0; settle();
    rd(1, 17, 32'h20, "R4"); chk_out(1'b1, 1'b0, "R4");
    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule